// File: doc/BRIEF.md
# SDRAM Activation Timing Guard

This block stands between a command requester and an SDRAM command bus. On every clock it looks at the requested command, bank and row and raises `grant` only when issuing that command on the coming rising edge breaks none of the activation timing rules. A command is taken as issued on any rising edge where `grant` is high. The requester holds a refused command steady and retries until it is granted.

The guard keeps, for each bank, whether a row is open, which row that is, and two down-counters. One counter covers the row-to-column delay and the other covers the same-bank activate-to-activate interval. A third counter, shared by all banks, covers the interval between activates to different banks. Each limit is given in picoseconds and converted at elaboration to whole clock cycles by rounding the quotient up. With the defaults this gives 3, 9 and 2 cycles.

Top module: `sdram_act_guard`

## Requirements
- R1: After reset every bank reads closed, every `open_row` slice reads zero, and a NOP is granted.
- R2: A granted ACTIVE (cmd code 1) opens the addressed bank, and from the next cycle `open_row` at slice `bank*ROW_W` shows the row presented with it.
- R3: A READ (code 2) or WRITE (code 3) is granted only if its bank is open and the edge is at least tRCD cycles after the ACTIVE edge of that bank. The default tRCD is 3 cycles.
- R4: An ACTIVE is granted only if its bank is closed and the edge is at least tRC cycles after that bank's previous ACTIVE edge. The default tRC is 9 cycles.
- R5: An ACTIVE to any bank is granted only if the edge is at least tRRD cycles after the most recent ACTIVE edge to any bank. The default tRRD is 2 cycles.
- R6: A PRECHARGE (code 4) is always granted. From the next cycle it shows the bank closed with `open_row` zero. A READ or WRITE to a closed bank is never granted.
- R7: A NOP (code 0) is always granted and changes no bank state.
- R8: Codes 5 to 7 are never granted and change no bank state.
- R9: Each cycle limit equals the nanosecond limit divided by the clock period, rounded up. For example, 20 ns at 7.5 ns gives 3 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; commands issue on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Requested command code: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE |
| bank | input | $clog2(NUM_BANKS) | Target bank |
| row | input | ROW_W | Row address carried by ACTIVE |
| grant | output | 1 | High when the requested command may issue on this edge |
| bank_open | output | NUM_BANKS | One bit per bank: a row is open |
| open_row | output | NUM_BANKS*ROW_W | Open row per bank, zero while closed |

## Verification
The embedded properties check every cycle that each issued READ/WRITE and ACTIVE respects the spacing measured by independent age counters. They also check that each issued command updates bank state as required, that NOP and undefined codes behave as required, and that at most one bank is touched per edge. Only the bench's scenarios can show that the guard does not refuse legal commands, which means showing that a stall releases on exactly the first permitted edge. The bench therefore compares every grant against a cycle-stamped reference model, using directed boundaries and long held-request random sequences.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_RD  = 3'd2,
      CMD_WR  = 3'd3,
      CMD_PRE = 3'd4
   } sag_cmd_e;

   // Whole cycles covering a time limit, rounded up
   function automatic int unsigned ps_to_cycles(input int unsigned t_ps,
                                                input int unsigned clk_ps);
      return (t_ps + clk_ps - 1) / clk_ps;
   endfunction

endpackage

// File: rtl/sag_bank_state.sv
module sag_bank_state #(
   parameter int unsigned ROW_W    = 14,
   parameter int unsigned TRCD_CYC = 3,
   parameter int unsigned TRC_CYC  = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_fire,
   input  logic             pre_fire,
   input  logic             rw_fire,
   input  logic [ROW_W-1:0] row_in,
   output logic             is_open,
   output logic [ROW_W-1:0] row_q,
   output logic             act_ok,
   output logic             rw_ok
);
   localparam int unsigned CW = $clog2(TRC_CYC + 1);

   logic [CW-1:0] rcd_cnt;
   logic [CW-1:0] rc_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         is_open <= 1'b0;
         row_q   <= '0;
         rcd_cnt <= '0;
         rc_cnt  <= '0;
      end else if (act_fire) begin
         is_open <= 1'b1;
         row_q   <= row_in;
         rcd_cnt <= CW'(TRCD_CYC - 1);
         rc_cnt  <= CW'(TRC_CYC - 1);
      end else begin
         if (pre_fire) begin
            is_open <= 1'b0;
            row_q   <= '0;
         end
         if (rcd_cnt != '0) rcd_cnt <= rcd_cnt - 1'b1;
         if (rc_cnt != '0)  rc_cnt  <= rc_cnt - 1'b1;
      end
   end

   assign act_ok = !is_open && (rc_cnt == '0);
   assign rw_ok  = is_open && (rcd_cnt == '0);

   // Independent age since last ACTIVE edge, saturating at TRC_CYC
   logic [CW-1:0] age_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                    age_q <= CW'(TRC_CYC);
      else if (act_fire)             age_q <= CW'(1);
      else if (age_q < CW'(TRC_CYC)) age_q <= age_q + 1'b1;
   end

   AST_RW_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      rw_fire |-> is_open); // R6
   AST_RCD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      rw_fire |-> (age_q >= CW'(TRCD_CYC))); // R3
   AST_RC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      act_fire |-> (!is_open && age_q >= CW'(TRC_CYC))); // R4
   AST_OPEN_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      act_fire |=> (is_open && row_q == $past(row_in))); // R2
   AST_CLOSED_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_fire && !act_fire) |=> (!is_open && row_q == '0)); // R6

endmodule

// File: rtl/sag_rrd_timer.sv
module sag_rrd_timer #(
   parameter int unsigned TRRD_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic any_act,
   output logic ready
);
   localparam int unsigned CW = $clog2(TRRD_CYC + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (any_act)    cnt <= CW'(TRRD_CYC - 1);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign ready = (cnt == '0);

   logic [CW-1:0] age_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                     age_q <= CW'(TRRD_CYC);
      else if (any_act)               age_q <= CW'(1);
      else if (age_q < CW'(TRRD_CYC)) age_q <= age_q + 1'b1;
   end

   AST_RRD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      any_act |-> (age_q >= CW'(TRRD_CYC))); // R5

endmodule

// File: rtl/sdram_act_guard.sv
module sdram_act_guard
   import sdram_guard_pkg::*;
#(
   parameter int unsigned NUM_BANKS    = 4,
   parameter int unsigned ROW_W        = 14,
   parameter int unsigned CLK_PS       = 7500,
   parameter int unsigned T_RCD_PS     = 20000,
   parameter int unsigned T_RC_PS      = 65000,
   parameter int unsigned T_RRD_PS     = 15000,
   localparam int unsigned BANK_W      = $clog2(NUM_BANKS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [2:0]                 cmd,
   input  logic [BANK_W-1:0]          bank,
   input  logic [ROW_W-1:0]           row,
   output logic                       grant,
   output logic [NUM_BANKS-1:0]       bank_open,
   output logic [NUM_BANKS*ROW_W-1:0] open_row
);
   // R9: cycle limits derived at elaboration, rounded up
   localparam int unsigned TRCD_CYC = ps_to_cycles(T_RCD_PS, CLK_PS);
   localparam int unsigned TRC_CYC  = ps_to_cycles(T_RC_PS, CLK_PS);
   localparam int unsigned TRRD_CYC = ps_to_cycles(T_RRD_PS, CLK_PS);

   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0)
      $error("NUM_BANKS must be a power of two, at least 2");
   if (CLK_PS == 0 || ROW_W == 0)
      $error("CLK_PS and ROW_W must be nonzero");
   if (TRCD_CYC < 1 || TRRD_CYC < 1 || TRC_CYC < TRCD_CYC)
      $error("timing limits must give tRCD>=1, tRRD>=1, tRC>=tRCD");

   sag_cmd_e cmd_e;
   assign cmd_e = sag_cmd_e'(cmd);

   logic [NUM_BANKS-1:0] act_ok, rw_ok, act_fire, pre_fire, rw_fire;
   logic                 rrd_ready;

   always_comb begin
      unique case (cmd)
         CMD_NOP, CMD_PRE: grant = 1'b1;
         CMD_ACT:          grant = act_ok[bank] && rrd_ready;
         CMD_RD, CMD_WR:   grant = rw_ok[bank];
         default:          grant = 1'b0;
      endcase
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit;
      assign hit         = grant && (bank == BANK_W'(b));
      assign act_fire[b] = hit && (cmd_e == CMD_ACT);
      assign pre_fire[b] = hit && (cmd_e == CMD_PRE);
      assign rw_fire[b]  = hit && (cmd_e == CMD_RD || cmd_e == CMD_WR);

      sag_bank_state #(
         .ROW_W    (ROW_W),
         .TRCD_CYC (TRCD_CYC),
         .TRC_CYC  (TRC_CYC)
      ) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .act_fire (act_fire[b]),
         .pre_fire (pre_fire[b]),
         .rw_fire  (rw_fire[b]),
         .row_in   (row),
         .is_open  (bank_open[b]),
         .row_q    (open_row[b*ROW_W +: ROW_W]),
         .act_ok   (act_ok[b]),
         .rw_ok    (rw_ok[b])
      );
   end

   // A one-cycle spacing needs no timer at all
   if (TRRD_CYC > 1) begin : g_rrd
      sag_rrd_timer #(.TRRD_CYC(TRRD_CYC)) u_rrd (
         .clk     (clk),
         .rst_n   (rst_n),
         .any_act (|act_fire),
         .ready   (rrd_ready)
      );
   end else begin : g_no_rrd
      assign rrd_ready = 1'b1;
   end

   AST_NOP_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 3'd0) |-> grant); // R7
   AST_NOP_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 3'd0) |=> ($stable(bank_open) && $stable(open_row))); // R7
   AST_BAD_CODE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd > 3'd4) |-> !grant); // R8
   AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(act_fire | pre_fire | rw_fire)); // R2

endmodule

// File: tb/tb_sdram_act_guard.sv
module tb_sdram_act_guard;
   localparam int NB    = 4;
   localparam int RW    = 14;
   localparam int TRCD  = (20000 + 7499) / 7500;  // 3
   localparam int TRC   = (65000 + 7499) / 7500;  // 9
   localparam int TRRD  = (15000 + 7499) / 7500;  // 2

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    cmd = 3'd0;
   logic [1:0]    bank = 2'd0;
   logic [RW-1:0] row = '0;
   logic          grant;
   logic [NB-1:0] bank_open;
   logic [NB*RW-1:0] open_row;

   always #10 clk = ~clk;

   sdram_act_guard dut (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .row(row),
      .grant(grant), .bank_open(bank_open), .open_row(open_row)
   );

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit m_open [NB];
   logic [RW-1:0] m_row [NB];
   int m_last [NB];
   int m_any;
   string st_tag = "R1";

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic step(input logic [2:0] c, input int b, input logic [RW-1:0] r,
                       output bit g);
      bit e;
      string tg;
      @(negedge clk);
      cmd = c; bank = 2'(b); row = r;
      #1;
      for (int i = 0; i < NB; i++) begin
         check(bank_open[i] == m_open[i], st_tag, int'(bank_open[i]), int'(m_open[i]));
         check(open_row[i*RW +: RW] == m_row[i], st_tag,
               int'(open_row[i*RW +: RW]), int'(m_row[i]));
      end
      case (c)
         3'd0: begin e = 1; tg = "R7"; end
         3'd1: begin e = !m_open[b] && (cyc - m_last[b] >= TRC) && (cyc - m_any >= TRRD);
                     tg = "R4/R5"; end
         3'd2, 3'd3: begin e = m_open[b] && (cyc - m_last[b] >= TRCD); tg = "R3/R6"; end
         3'd4: begin e = 1; tg = "R6"; end
         default: begin e = 0; tg = "R8"; end
      endcase
      check(grant == e, tg, int'(grant), int'(e));
      g = e;
      @(posedge clk);
      if (e && c == 3'd1) begin
         m_open[b] = 1; m_row[b] = r; m_last[b] = cyc; m_any = cyc;
      end else if (e && c == 3'd4) begin
         m_open[b] = 0; m_row[b] = '0;
      end
      cyc++;
   endtask

   initial begin
      #4000000;
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      bit g;
      int t0;
      for (int i = 0; i < NB; i++) begin m_open[i] = 0; m_row[i] = '0; m_last[i] = -1000; end
      m_any = -1000;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1: reset state, NOP granted
      st_tag = "R1";
      step(3'd0, 0, '0, g);
      st_tag = "R2";
      // R2/R3: ACT then READ held until tRCD elapses
      step(3'd1, 0, 14'h155, g);
      t0 = cyc - 1;
      g = 0;
      while (!g) step(3'd2, 0, '0, g);
      check(cyc - 1 - t0 == TRCD, "R3", cyc - 1 - t0, TRCD);
      // R5: ACT to two banks back to back
      step(3'd1, 1, 14'h2AA, g);
      t0 = cyc - 1;
      g = 0;
      while (!g) step(3'd1, 2, 14'h3FFF, g);
      check(cyc - 1 - t0 == TRRD, "R5", cyc - 1 - t0, TRRD);
      // R4: reopen bank 1 after precharge waits for tRC
      st_tag = "R6";
      step(3'd4, 1, '0, g);
      g = 0;
      while (!g) step(3'd1, 1, 14'h0042, g);
      check(cyc - 1 - t0 == TRC, "R4", cyc - 1 - t0, TRC);
      // R6: write to a closed bank refused; R8: bad codes refused
      step(3'd3, 3, '0, g);
      st_tag = "R8";
      for (int k = 5; k < 8; k++) step(3'(k), 0, 14'h1234, g);
      step(3'd0, 0, '0, g);  // R8: state unchanged, checked here
      // R9 is covered by the spacings above; now long held-request sweep
      st_tag = "R2/R6";
      begin
         logic [2:0] c = 3'd0;
         int b = 0;
         logic [RW-1:0] r = '0;
         g = 1;
         for (int n = 0; n < 6000; n++) begin
            if (g || ($urandom % 4 == 0)) begin
               c = 3'($urandom % 6);
               if ($urandom % 10 == 0) c = 3'(5 + $urandom % 3);
               b = int'($urandom % NB);
               r = RW'($urandom);
            end
            step(c, b, r, g);
         end
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule